// File: doc/BRIEF.md
# Double-Buffered Time-Tagged Event Recorder

This block logs change-of-state events in the order they arrive. Each logged entry holds a 16-bit millisecond time tag, a 6-bit channel number and the new input level. The block runs its own millisecond counter, which advances on each pulse of a tick input. The counter wraps from its maximum back to zero and leaves a sticky flag for the host when it does.

Entries are written into one of two equal banks. When the bank being written fills, writing moves to the other bank, so software can drain the full bank while recording continues. Software frees a bank through a register write, which zeroes that bank's fill count. If writing moves to a bank that has not been freed, new events are discarded and a sticky overflow flag is raised. An interrupt output combines three enabled sources: a full bank, a programmable fill count being reached, and a timer wrap.

Software reaches status, counts, the threshold, the timer, the interrupt enables and every stored entry through a simple address/data register port with registered read data. The bank size is the `DEPTH` parameter. It can be set as high as 3000 entries per bank.

Top module: `soe_pingpong_rec`

## Requirements
- R1: After reset, bank 0 is active, both fill counts are zero, all status flags are clear, the timer reads zero and `irq` is low.
- R2: Each cycle with `ms_tick` high advances the timer (address 3, bits [15:0]) by one.
- R3: On a tick with the timer at 0xFFFF, the timer returns to 0 and the rollover flag (STATUS bit 2) is set. The flag stays set until CONTROL bit 3 is written with 1.
- R4: An event strobe stores an entry at index = current fill count of the active bank. The entry is laid out as [15:0] timer value in the strobe cycle, [21:16] channel, [22] level. It is read at address bit15=1, bit14=bank, low bits=index.
- R5: When a store brings the active bank's count to `DEPTH`, that bank's full bit is set and the active bank toggles. The full bits are STATUS bit 3 for bank 0 and bit 4 for bank 1. STATUS bit 0 gives the active bank.
- R6: An event that reaches an active bank already holding `DEPTH` entries is dropped and leaves both counts unchanged. The drop sets the sticky overflow flag (STATUS bit 1), which CONTROL bit 2 clears.
- R7: Writing CONTROL (address 4) with bit 0 or bit 1 set releases bank 0 or bank 1. A release zeroes that bank's count and clears its full bit, and later events are again stored in that bank from index 0.
- R8: When a store makes the active bank's count equal to a nonzero THRESH (address 2, bits [15:0]), STATUS bit 5 is set. CONTROL bit 4 clears it. A THRESH of zero never sets it.
- R9: `irq` is high when an enabled source is pending. IRQ_EN is at address 5. Bit 0 enables either full bit, bit 1 enables the threshold flag and bit 2 enables the rollover flag.
- R10: `reg_rdata` shows the register or entry selected by `reg_addr` one clock after the address is applied. COUNTS (address 1) holds bank 0 in [15:0] and bank 1 in [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ev_valid | input | 1 | Event strobe |
| ev_chan | input | 6 | Channel number of the event |
| ev_level | input | 1 | New level of the channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register or entry address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
A strobe, tick or register write changes the block's state at the rising edge that samples it. `irq` is decoded from registered flags, so it is correct right after that same edge. Read data passes through one more register, so a value is due one clock after its address is presented. The bench drives every input on the falling edge. It takes `irq` at the falling edge after the state-changing edge. It takes `reg_rdata` at the falling edge that follows one rising edge with the address held, and never samples on a rising edge.

// File: rtl/soe_pkg.sv
package soe_pkg;

  localparam int TS_W    = 16;
  localparam int CHAN_W  = 6;
  localparam int ENTRY_W = TS_W + CHAN_W + 1;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;

  // register offsets inside the control region (reg_addr[15] == 0)
  localparam logic [2:0] ADR_STATUS = 3'd0;
  localparam logic [2:0] ADR_COUNTS = 3'd1;
  localparam logic [2:0] ADR_THRESH = 3'd2;
  localparam logic [2:0] ADR_TIMER  = 3'd3;
  localparam logic [2:0] ADR_CTRL   = 3'd4;
  localparam logic [2:0] ADR_IRQEN  = 3'd5;

  typedef struct packed {
    logic              level;
    logic [CHAN_W-1:0] chan;
    logic [TS_W-1:0]   stamp;
  } soe_entry_t;

  function automatic soe_entry_t make_entry(input logic [TS_W-1:0] ts,
                                            input logic [CHAN_W-1:0] ch,
                                            input logic lvl);
    soe_entry_t e;
    e.level = lvl;
    e.chan  = ch;
    e.stamp = ts;
    return e;
  endfunction

  // {wrap, next value}
  function automatic logic [TS_W:0] timer_step(input logic [TS_W-1:0] t);
    return {&t, TS_W'(t + 1'b1)};
  endfunction

endpackage

// File: rtl/soe_ms_timer.sv
module soe_ms_timer
  import soe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  output logic [TS_W-1:0] value_o,
  output logic            wrap_o
);

  logic [TS_W:0] step;

  assign step   = timer_step(value_o);
  assign wrap_o = tick_i & step[TS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value_o <= '0;
    else if (tick_i) value_o <= step[TS_W-1:0];
  end

endmodule

// File: rtl/soe_bank.sv
module soe_bank #(
  parameter int DEPTH = 32,
  parameter int W     = 23,
  parameter int CNT_W = 6,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [W-1:0]     data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic [W-1:0]     rd_data_o
);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] base;

  // a release in the same cycle restarts the bank before the write lands
  assign base = clr_i ? '0 : cnt_o;

  always_ff @(posedge clk) begin
    if (wr_i) mem[base[IDX_W-1:0]] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (wr_i)  cnt_o <= base + 1'b1;
    else if (clr_i) cnt_o <= '0;
  end

  assign full_o    = (cnt_o == CNT_W'(DEPTH));
  assign rd_data_o = mem[rd_idx_i];

endmodule

// File: rtl/soe_pingpong_rec.sv
module soe_pingpong_rec
  import soe_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              ev_valid,
  input  logic [CHAN_W-1:0] ev_chan,
  input  logic              ev_level,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // timer
  logic [TS_W-1:0] timer;
  logic            wrap_evt;

  soe_ms_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (ms_tick),
    .value_o (timer),
    .wrap_o  (wrap_evt)
  );

  // register write decode
  logic       reg_space;
  logic       wr_ctrl, wr_thresh, wr_irqen;
  logic [1:0] rel;
  logic       clr_ovf, clr_roll, clr_thr;

  assign reg_space = (reg_addr[ADDR_W-1:3] == '0);
  assign wr_ctrl   = reg_wr && reg_space && (reg_addr[2:0] == ADR_CTRL);
  assign wr_thresh = reg_wr && reg_space && (reg_addr[2:0] == ADR_THRESH);
  assign wr_irqen  = reg_wr && reg_space && (reg_addr[2:0] == ADR_IRQEN);
  assign rel       = {2{wr_ctrl}} & reg_wdata[1:0];
  assign clr_ovf   = wr_ctrl & reg_wdata[2];
  assign clr_roll  = wr_ctrl & reg_wdata[3];
  assign clr_thr   = wr_ctrl & reg_wdata[4];

  // state
  logic            act;
  logic            ovf_flag, roll_flag, thr_flag;
  logic [TS_W-1:0] thresh;
  logic [2:0]      irq_en;

  // banks
  logic [CNT_W-1:0]   cnt     [2];
  logic [ENTRY_W-1:0] rd_word [2];
  logic [1:0]         full_b;
  logic [1:0]         wr_b;
  logic               store_evt, drop_evt, fill_evt, thr_evt;
  logic [CNT_W-1:0]   act_base, new_cnt;
  soe_entry_t         entry;

  assign entry = make_entry(timer, ev_chan, ev_level);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign wr_b[b] = store_evt && (act == 1'(b));
    soe_bank #(
      .DEPTH (DEPTH),
      .W     (ENTRY_W),
      .CNT_W (CNT_W),
      .IDX_W (IDX_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (rel[b]),
      .wr_i      (wr_b[b]),
      .data_i    (entry),
      .rd_idx_i  (reg_addr[IDX_W-1:0]),
      .cnt_o     (cnt[b]),
      .full_o    (full_b[b]),
      .rd_data_o (rd_word[b])
    );
  end

  // event steering, brought out as named wires
  assign act_base  = rel[act] ? '0 : cnt[act];
  assign store_evt = ev_valid && (act_base != CNT_W'(DEPTH));
  assign drop_evt  = ev_valid && !store_evt;
  assign new_cnt   = act_base + 1'b1;
  assign fill_evt  = store_evt && (new_cnt == CNT_W'(DEPTH));
  assign thr_evt   = store_evt && (thresh != '0) && (TS_W'(new_cnt) == thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= 1'b0;
      ovf_flag  <= 1'b0;
      roll_flag <= 1'b0;
      thr_flag  <= 1'b0;
      thresh    <= '0;
      irq_en    <= '0;
    end else begin
      if (fill_evt) act <= ~act;
      if (drop_evt)      ovf_flag <= 1'b1;
      else if (clr_ovf)  ovf_flag <= 1'b0;
      if (wrap_evt)      roll_flag <= 1'b1;
      else if (clr_roll) roll_flag <= 1'b0;
      if (thr_evt)       thr_flag <= 1'b1;
      else if (clr_thr)  thr_flag <= 1'b0;
      if (wr_thresh) thresh <= reg_wdata[TS_W-1:0];
      if (wr_irqen)  irq_en <= reg_wdata[2:0];
    end
  end

  assign irq = ((|full_b) & irq_en[0]) | (thr_flag & irq_en[1]) | (roll_flag & irq_en[2]);

  // read path
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (reg_addr[ADDR_W-1]) begin
      rd_next = DATA_W'(rd_word[reg_addr[ADDR_W-2]]);
    end else if (reg_space) begin
      case (reg_addr[2:0])
        ADR_STATUS: rd_next = DATA_W'({thr_flag, full_b, roll_flag, ovf_flag, act});
        ADR_COUNTS: rd_next = {16'(cnt[1]), 16'(cnt[0])};
        ADR_THRESH: rd_next = DATA_W'(thresh);
        ADR_TIMER:  rd_next = DATA_W'(timer);
        ADR_IRQEN:  rd_next = DATA_W'(irq_en);
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:TS_W];

endmodule

// File: rtl/soe_pingpong_rec_chk.sv
module soe_pingpong_rec_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ms_tick,
  input logic [15:0]      timer,
  input logic             roll_flag,
  input logic             act,
  input logic             store_evt,
  input logic             drop_evt,
  input logic             fill_evt,
  input logic             ovf_flag,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [1:0]       rel,
  input logic [2:0]       irq_en,
  input logic             irq
);

  // R2
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_tick && timer != 16'hFFFF) |=> timer == $past(timer) + 16'd1);

  // R3
  timer_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_tick && timer == 16'hFFFF) |=> (timer == 16'd0 && roll_flag));

  // R5
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> act != $past(act));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_evt && !fill_evt) |=> act == $past(act));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_flag);

  // R6
  drop_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && rel == 2'b00) |=> (cnt0 == $past(cnt0) && cnt1 == $past(cnt1)));

  // R7
  release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel[0] && !(store_evt && !act)) |=> cnt0 == '0);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 3'b000) |-> !irq);

  // R4
  always_comb begin
    if (rst_n) begin
      count_bound_chk: assert (cnt0 <= CNT_W'(DEPTH) && cnt1 <= CNT_W'(DEPTH));
    end
  end

endmodule

bind soe_pingpong_rec soe_pingpong_rec_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ms_tick   (ms_tick),
  .timer     (timer),
  .roll_flag (roll_flag),
  .act       (act),
  .store_evt (store_evt),
  .drop_evt  (drop_evt),
  .fill_evt  (fill_evt),
  .ovf_flag  (ovf_flag),
  .cnt0      (cnt[0]),
  .cnt1      (cnt[1]),
  .rel       (rel),
  .irq_en    (irq_en),
  .irq       (irq)
);

// File: tb/soe_pingpong_rec_bench.sv
module soe_pingpong_rec_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ms_tick;
  logic        ev_valid;
  logic [5:0]  ev_chan;
  logic        ev_level;
  logic        reg_wr;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soe_pingpong_rec #(.DEPTH(DEPTH)) u_soe_pingpong_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .ev_valid  (ev_valid),
    .ev_chan   (ev_chan),
    .ev_level  (ev_level),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  typedef struct packed {
    logic [7:0] ticks;
    logic [5:0] ch;
    logic       lvl;
    logic       bank;
    logic [1:0] idx;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd2, 6'd5,  1'b1, 1'b0, 2'd0},
    '{8'd0, 6'd63, 1'b0, 1'b0, 2'd1},
    '{8'd7, 6'd0,  1'b1, 1'b0, 2'd2},
    '{8'd1, 6'd17, 1'b1, 1'b0, 2'd3},
    '{8'd3, 6'd42, 1'b0, 1'b1, 2'd0},
    '{8'd0, 6'd8,  1'b1, 1'b1, 2'd1}
  };

  int unsigned ts = 0;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  // R10: data is due one rising edge after the address
  task automatic rd_reg(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    step();
    d = reg_rdata;
  endtask

  task automatic post_ev(input logic [5:0] c, input logic l);
    ev_valid = 1'b1; ev_chan = c; ev_level = l;
    step();
    ev_valid = 1'b0;
  endtask

  task automatic give_ticks(input int n);
    if (n > 0) begin
      ms_tick = 1'b1;
      repeat (n) step();
      ms_tick = 1'b0;
      ts = (ts + n) % 65536;
    end
  endtask

  function automatic logic [31:0] ent(input int unsigned t, input logic [5:0] c, input logic l);
    return {9'd0, l, c, t[15:0]};
  endfunction

  function automatic logic [15:0] ent_addr(input logic b, input logic [1:0] i);
    return {1'b1, b, 12'd0, i};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; ms_tick = 1'b0; ev_valid = 1'b0; ev_chan = '0; ev_level = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(16'd0, d); chk("R1 status", d, 32'h0);
    rd_reg(16'd1, d); chk("R1 counts", d, 32'h0);
    rd_reg(16'd3, d); chk("R1/R10 timer", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    wr_reg(16'd2, 32'd3);      // THRESH = 3
    wr_reg(16'd5, 32'h2);      // threshold interrupt only

    // R4 / R2 vector walk
    for (int i = 0; i < 6; i++) begin
      give_ticks(int'(VECS[i].ticks));
      post_ev(VECS[i].ch, VECS[i].lvl);
      rd_reg(ent_addr(VECS[i].bank, VECS[i].idx), d);
      chk($sformatf("R4 entry %0d", i), d, ent(ts, VECS[i].ch, VECS[i].lvl));
    end

    // R5 swap, R8 threshold, R10 count layout
    rd_reg(16'd0, d); chk("R5/R8 status", d, 32'h29);
    rd_reg(16'd1, d); chk("R10 counts", d, 32'h0002_0004);
    rd_reg(16'd3, d); chk("R2 timer", d, 32'd13);
    chk("R9 threshold irq", {31'd0, irq}, 32'd1);

    wr_reg(16'd4, 32'h10);     // clear threshold flag
    wr_reg(16'd5, 32'h1);      // full interrupt only
    chk("R9 full irq", {31'd0, irq}, 32'd1);
    wr_reg(16'd5, 32'h0);
    chk("R9 disabled irq", {31'd0, irq}, 32'd0);

    // R6 both banks full
    post_ev(6'd1, 1'b1);
    post_ev(6'd2, 1'b0);
    post_ev(6'd3, 1'b1);
    rd_reg(16'd0, d); chk("R6 status", d, 32'h3A);
    rd_reg(16'd1, d); chk("R6 counts", d, 32'h0004_0004);

    // R7 release bank 0
    wr_reg(16'd4, 32'h1);
    rd_reg(16'd0, d); chk("R7 status", d, 32'h32);
    rd_reg(16'd1, d); chk("R7 counts", d, 32'h0004_0000);
    post_ev(6'd9, 1'b0);
    rd_reg(ent_addr(1'b0, 2'd0), d); chk("R7 entry", d, ent(ts, 6'd9, 1'b0));
    wr_reg(16'd4, 32'h4);      // clear overflow
    rd_reg(16'd0, d); chk("R6 ovf clear", d, 32'h30);

    // R8 threshold zero disables
    wr_reg(16'd2, 32'd0);
    wr_reg(16'd4, 32'h10);
    post_ev(6'd10, 1'b1);
    post_ev(6'd11, 1'b1);
    rd_reg(16'd0, d); chk("R8 zero threshold", d, 32'h10);
    rd_reg(16'd1, d); chk("R8 counts", d, 32'h0004_0003);

    // R3 rollover
    wr_reg(16'd5, 32'h4);
    give_ticks(65535 - int'(ts));
    rd_reg(16'd3, d); chk("R2 timer max", d, 32'h0000_FFFF);
    chk("R9 rollover idle", {31'd0, irq}, 32'd0);
    give_ticks(1);
    rd_reg(16'd3, d); chk("R3 timer wrap", d, 32'd0);
    rd_reg(16'd0, d); chk("R3 status", d, 32'h14);
    chk("R9 rollover irq", {31'd0, irq}, 32'd1);
    wr_reg(16'd4, 32'h8);
    rd_reg(16'd0, d); chk("R3 clear", d, 32'h10);
    chk("R9 rollover cleared", {31'd0, irq}, 32'd0);

    finish_run();
  end

endmodule